// File: doc/BRIEF.md
# Dual-Output Direct Pin Gate

This block decides, for each of two load outputs, whether the load is commanded on. Each output has a serial-programmed command bit, held elsewhere and presented here as a level. Each output also has an external input pin. A per-output configuration decides how the two are merged:

- The pin can be ignored, so the command bit alone drives the output.
- The pin can be ORed with the command bit.
- The pin can be ANDed with the command bit. In this mode one common PWM signal can be wired to the pins of several outputs, and each output's command bit decides whether that PWM reaches its load.

Configuration arrives as a decoded register-write strobe with an 8-bit data byte. The top bit of the byte picks the output that the write configures. Bit 1 turns pin control off for that output, and bit 0 picks AND or OR. The raw pins are asynchronous, so they pass through a two-flop synchronizer before they are merged. The result is one on/off command per output, which goes to the output drivers.

Top module: `dual_pin_gate`

## Requirements
- R1: A configuration write changes only the output picked by data bit 7 (0 = output 0, 1 = output 1). The other output keeps its settings.
- R2: A write with data bit 1 = 1 turns pin control off for the picked output. Bit 1 = 0 turns it on.
- R3: With pin control on and data bit 0 = 1 (AND mode), the output is the synchronized pin ANDed with that output's command bit.
- R4: With pin control on and data bit 0 = 0 (OR mode), the output is the synchronized pin ORed with that output's command bit.
- R5: With pin control off, the output equals its command bit, and any pin activity has no effect.
- R6: After reset, both outputs have pin control on in OR mode and the synchronizers hold 0. With the command bits and pins at 0, both outputs are 0.
- R7: A pin level set up before clock edge k appears at the output after edge k+1 (two synchronizer flops). Command bits act on the output without any clock delay.
- R8: A write whose strobe is high at a clock edge governs the output from that edge on.
- R9: In AND mode, one PWM pattern driven on both pins reaches only the outputs whose command bit is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Decoded write strobe for the pin-control register |
| cfg_data | input | 8 | Write data: bit 7 target output, bit 1 pin off, bit 0 AND mode |
| cmd_bits | input | 2 | Per-output serial command bits |
| pin_raw | input | 2 | Asynchronous direct input pins |
| drive_out | output | 2 | Merged on/off command per output |

## Verification
A configuration write and a pin edge can reach the same output in the same cycle, as can a write to one output while the other output's pin is toggling. The bench provokes both:

- It issues writes at the same clock edge as a PWM pin transition.
- It writes to output 1 while output 0 runs in AND mode.

A scoreboard judges the result. Its reference model latches the new mode at the write edge, shifts pins through two stages, and predicts each output in every cycle. A wrong latency, a write landing on the wrong output, or a mode applied one cycle early or late all show up as a mismatch.

// File: rtl/dpg_pkg.sv
// Package: shared types for the dual pin gate.
// Assumes: one configuration record per output, cleared by reset.
package dpg_pkg;

    // Per-output configuration held between writes
    typedef struct packed {
        logic pin_off;   // 1: pin ignored, output follows command bit
        logic and_mode;  // 1: AND merge, 0: OR merge
    } gate_cfg_t;

    localparam gate_cfg_t CFG_RESET = '{pin_off: 1'b0, and_mode: 1'b0};

endpackage

// File: rtl/dpg_pin_sync.sv
// Module: multi-stage synchronizer for asynchronous input pins.
// Assumes: STAGES >= 2; each bit is an independent level signal.
module dpg_pin_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] pipe_q [STAGES];

    // Shift pin levels through the flop chain, cleared on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) pipe_q[k] <= '0;
        end else begin
            pipe_q[0] <= din;
            for (int k = 1; k < STAGES; k++) pipe_q[k] <= pipe_q[k-1];
        end
    end

    assign dout = pipe_q[STAGES-1];

endmodule

// File: rtl/dpg_cfg_bank.sv
// Module: per-output configuration registers loaded from a decoded write.
// Assumes: the select field sits at SEL_BIT downward; only the picked
// output is updated, and the update is visible after the write edge.
module dpg_cfg_bank
    import dpg_pkg::*;
#(
    parameter int N_OUT    = 2,
    parameter int DATA_W   = 8,
    parameter int SEL_BIT  = 7,
    parameter int OFF_BIT  = 1,
    parameter int MODE_BIT = 0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [DATA_W-1:0]     wr_data,
    output gate_cfg_t [N_OUT-1:0] cfg_q
);

    localparam int SEL_W = (N_OUT > 1) ? $clog2(N_OUT) : 1;

    logic [SEL_W-1:0] sel;
    logic             unused_data;

    // Extract the target-output field of the written byte
    assign sel         = wr_data[SEL_BIT -: SEL_W];
    assign unused_data = ^wr_data;

    for (genvar i = 0; i < N_OUT; i++) begin : g_slot
        // Load this output's settings when the write targets it
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg_q[i] <= CFG_RESET;
            end else if (wr_en && (sel == SEL_W'(i))) begin
                cfg_q[i].pin_off  <= wr_data[OFF_BIT];
                cfg_q[i].and_mode <= wr_data[MODE_BIT];
            end
        end
    end

endmodule

// File: rtl/dpg_merge.sv
// Module: combinational merge of synchronized pin and command bit.
// Assumes: inputs are already synchronous to clk.
module dpg_merge
    import dpg_pkg::*;
#(
    parameter int N_OUT = 2
) (
    input  gate_cfg_t [N_OUT-1:0] cfg,
    input  logic [N_OUT-1:0]      pin_s,
    input  logic [N_OUT-1:0]      cmd,
    output logic [N_OUT-1:0]      drive
);

    for (genvar i = 0; i < N_OUT; i++) begin : g_out
        // Pick command-only, AND or OR merge for this output
        always_comb begin
            if (cfg[i].pin_off)       drive[i] = cmd[i];
            else if (cfg[i].and_mode) drive[i] = pin_s[i] & cmd[i];
            else                      drive[i] = pin_s[i] | cmd[i];
        end
    end

endmodule

// File: rtl/dual_pin_gate.sv
// Module: top of the dual direct-pin gate.
// Assumes: cfg_wr is a single-cycle decoded strobe; cmd_bits are synchronous
// levels; pin_raw is asynchronous and gets synchronized here.
module dual_pin_gate
    import dpg_pkg::*;
#(
    parameter int N_OUT       = 2,
    parameter int DATA_W      = 8,
    parameter int SEL_BIT     = 7,
    parameter int OFF_BIT     = 1,
    parameter int MODE_BIT    = 0,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [DATA_W-1:0] cfg_data,
    input  logic [N_OUT-1:0]  cmd_bits,
    input  logic [N_OUT-1:0]  pin_raw,
    output logic [N_OUT-1:0]  drive_out
);

    gate_cfg_t [N_OUT-1:0] cfg_q;
    logic [N_OUT-1:0]      pin_s;

    dpg_pin_sync #(.W(N_OUT), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pin_raw),
        .dout (pin_s)
    );

    dpg_cfg_bank #(
        .N_OUT(N_OUT), .DATA_W(DATA_W), .SEL_BIT(SEL_BIT),
        .OFF_BIT(OFF_BIT), .MODE_BIT(MODE_BIT)
    ) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cfg_wr),
        .wr_data(cfg_data),
        .cfg_q  (cfg_q)
    );

    dpg_merge #(.N_OUT(N_OUT)) u_merge (
        .cfg  (cfg_q),
        .pin_s(pin_s),
        .cmd  (cmd_bits),
        .drive(drive_out)
    );

endmodule

// File: rtl/dpg_chk.sv
// Module: assertion checker for dual_pin_gate, attached by bind.
// Assumes: it sees the top's ports and its configuration registers.
module dpg_chk
    import dpg_pkg::*;
#(
    parameter int N_OUT    = 2,
    parameter int DATA_W   = 8,
    parameter int SEL_BIT  = 7,
    parameter int OFF_BIT  = 1,
    parameter int MODE_BIT = 0
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cfg_wr,
    input logic [DATA_W-1:0]     cfg_data,
    input logic [N_OUT-1:0]      cmd_bits,
    input logic [N_OUT-1:0]      drive_out,
    input gate_cfg_t [N_OUT-1:0] cfg_q
);

    localparam int SEL_W = (N_OUT > 1) ? $clog2(N_OUT) : 1;

    logic [SEL_W-1:0] sel;
    assign sel = cfg_data[SEL_BIT -: SEL_W];

    for (genvar i = 0; i < N_OUT; i++) begin : g_a
        // R1
        other_untouched_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_wr && sel != SEL_W'(i)) |=> $stable(cfg_q[i]));
        // R2
        pin_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_wr && sel == SEL_W'(i) && cfg_data[OFF_BIT]) |=> (drive_out[i] == cmd_bits[i]));
        // R3
        and_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_wr && sel == SEL_W'(i) && !cfg_data[OFF_BIT] && cfg_data[MODE_BIT])
            |=> (!drive_out[i] || cmd_bits[i]));
        // R4
        or_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_wr && sel == SEL_W'(i) && !cfg_data[OFF_BIT] && !cfg_data[MODE_BIT])
            |=> (!cmd_bits[i] || drive_out[i]));
    end

    // R6
    known_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown(drive_out));

endmodule

bind dual_pin_gate dpg_chk #(
    .N_OUT(N_OUT), .DATA_W(DATA_W), .SEL_BIT(SEL_BIT),
    .OFF_BIT(OFF_BIT), .MODE_BIT(MODE_BIT)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_wr   (cfg_wr),
    .cfg_data (cfg_data),
    .cmd_bits (cmd_bits),
    .drive_out(drive_out),
    .cfg_q    (cfg_q)
);

// File: tb/dual_pin_gate_tb_top.sv
// Scoreboard bench: the driver predicts every cycle, the monitor compares.
module dual_pin_gate_tb_top;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_data = '0;
    logic [1:0] cmd_bits = '0;
    logic [1:0] pin_raw = '0;
    logic [1:0] drive_out;

    int total = 0;
    int bad = 0;

    typedef struct {
        logic [1:0] exp;
        string      tag;
    } sb_item_t;

    sb_item_t sb_q[$];

    // Reference state built from the requirements
    logic [1:0] m_s1 = '0, m_s2 = '0;
    logic [1:0] m_off = '0, m_and = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_pin_gate dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_data(cfg_data),
        .cmd_bits(cmd_bits), .pin_raw(pin_raw), .drive_out(drive_out)
    );

    function automatic logic [1:0] predict(input logic [1:0] c);
        logic [1:0] r;
        for (int i = 0; i < 2; i++) begin
            if (m_off[i])      r[i] = c[i];               // R5
            else if (m_and[i]) r[i] = m_s2[i] & c[i];     // R3
            else               r[i] = m_s2[i] | c[i];     // R4
        end
        return r;
    endfunction

    // Drive one cycle, advance the model at the edge, queue the expectation
    task automatic step(input logic wr, input logic [7:0] d,
                        input logic [1:0] c, input logic [1:0] p, input string tag);
        @(negedge clk);
        cfg_wr = wr; cfg_data = d; cmd_bits = c; pin_raw = p;
        @(posedge clk);
        m_s2 = m_s1; m_s1 = p;                            // R7
        if (wr) begin                                     // R1 R8
            m_off[d[7]] = d[1];
            m_and[d[7]] = d[0];
        end
        sb_q.push_back('{predict(c), tag});
    endtask

    task automatic pwm(input int n, input logic [1:0] c, input string tag);
        for (int k = 0; k < n; k++)
            step(1'b0, 8'h00, c, (k % 2 == 0) ? 2'b11 : 2'b00, tag);
    endtask

    // Monitor: compare at a quarter period after each edge
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (sb_q.size() > 0) begin
                sb_item_t it;
                it = sb_q.pop_front();
                total++;
                if (drive_out !== it.exp) begin
                    bad++;
                    $display("FAIL %s: drive_out=%b expected=%b", it.tag, drive_out, it.exp);
                end
            end
        end
    end

    // Watchdog
    initial begin
        #(CLK_PERIOD * 100000);
        bad++;
        $display("FAIL watchdog: run did not end, actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #(CLK_PERIOD/4);
        total++;
        if (drive_out !== 2'b00) begin  // R6
            bad++;
            $display("FAIL R6 reset: drive_out=%b expected=00", drive_out);
        end
        @(negedge clk);
        rst_n = 1'b1;
        // R6 R7: default OR mode, pin reaches output after two edges
        step(1'b0, 8'h00, 2'b00, 2'b01, "R7 pin latency");
        step(1'b0, 8'h00, 2'b00, 2'b01, "R7 pin latency");
        step(1'b0, 8'h00, 2'b00, 2'b10, "R6 default OR");
        step(1'b0, 8'h00, 2'b00, 2'b00, "R6 default OR");
        step(1'b0, 8'h00, 2'b00, 2'b00, "R6 default OR");
        // R2 R5 R8: turn pin off on output 0 while pin is high
        step(1'b0, 8'h00, 2'b00, 2'b01, "R7 pin latency");
        step(1'b0, 8'h00, 2'b00, 2'b01, "R7 pin latency");
        step(1'b1, 8'h03, 2'b00, 2'b01, "R8 write edge");
        pwm(4, 2'b00, "R5 pin ignored");
        step(1'b0, 8'h00, 2'b01, 2'b00, "R5 cmd only");
        step(1'b0, 8'h00, 2'b01, 2'b11, "R5 cmd only");
        // R3: AND mode on output 0, written during a pin edge
        step(1'b1, 8'h01, 2'b01, 2'b00, "R3 write with pin edge");
        pwm(6, 2'b01, "R3 AND cmd high");
        pwm(4, 2'b00, "R3 AND cmd low");
        // R9: both outputs AND, shared PWM gated by command bits
        step(1'b1, 8'h81, 2'b01, 2'b11, "R9 write out1");
        pwm(6, 2'b01, "R9 only out0");
        pwm(6, 2'b10, "R9 only out1");
        pwm(4, 2'b11, "R9 both");
        // R4: OR mode on output 1
        step(1'b1, 8'h80, 2'b10, 2'b00, "R4 OR write");
        step(1'b0, 8'h00, 2'b10, 2'b00, "R4 cmd high");
        pwm(4, 2'b00, "R4 pin only");
        // R1: writing output 1 leaves output 0 in AND mode
        step(1'b1, 8'h82, 2'b10, 2'b11, "R1 write out1 off");
        pwm(6, 2'b00, "R1 out0 still AND");
        pwm(4, 2'b11, "R1 out0 AND out1 cmd");
        // R2: turn pin control back on for output 0 in OR mode
        step(1'b1, 8'h00, 2'b00, 2'b01, "R2 pin on again");
        pwm(4, 2'b00, "R2 OR restored");
        step(1'b0, 8'h00, 2'b00, 2'b00, "R2 drain");
        repeat (3) @(posedge clk);
        #(CLK_PERIOD);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule